// File: doc/BRIEF.md
# Command-Macro Execute Unit

This block is the arithmetic and bitfield stage of a small 32-bit command-macro processor. It takes one instruction word at a time, names the two source registers it needs on a pair of index outputs, and receives their contents from an external register file on the same cycle. Register index 0 is treated as a constant zero whatever the register file returns. Depending on the class in the low three bits, the unit performs register-register arithmetic or logic, an add with a signed immediate, one of three bitfield operations, or a state read at a computed address. A single carry flag persists from one instruction to the next, so that multi-word additions and subtractions can be chained.

Results appear one cycle after the instruction is accepted, with a valid pulse, an illegal-encoding flag and the current carry. A read-immediate instruction instead raises a one-cycle request carrying the address and holds the unit busy until the responder acknowledges it; the returned data then becomes the result on the following cycle. Branch words (class 7) are accepted but produce no result, since sequencing lives elsewhere, as do result write-back and parameter fetch.

Top module: `mcr_exec`

## Requirements
- R1: While reset is low and in the first cycle after it, res_vld, busy and st_req are 0 and carry is 0.
- R2: ra_idx equals instruction bits 13:11 and rb_idx equals bits 16:14 in the same cycle; an index of 0 supplies the value 0 regardless of ra_data or rb_data.
- R3: Class 0 with function bits 21:17 = 0 (add) returns A+B and sets carry when the unsigned sum exceeds 0xFFFFFFFF; function 1 (add-with-carry) also adds the current carry.
- R4: Class 0 function 2 (subtract) returns A-B with carry = 1 when A >= B unsigned; function 3 (subtract-with-borrow) returns A-B-(1-carry) with carry = 1 when that difference does not go below zero.
- R5: Class 0 functions 8, 9, 10, 11 and 12 return A XOR B, A OR B, A AND B, A AND NOT B and NOT (A AND B) respectively.
- R6: Class 1 returns A plus the immediate, bits 31:14 sign-extended to 32 bits.
- R7: Class 2 (field insert) returns A with the field of width size (bits 26:22) at position dst (bits 31:27) replaced by the size low bits of B shifted right by src (bits 21:17); mask = (1<<size)-1, so size 0 returns A unchanged.
- R8: Class 3 returns ((B >> A[4:0]) & mask) << dst.
- R9: Class 4 returns ((B >> src) & mask) << A[4:0].
- R10: Class 5 raises st_req for exactly one cycle, one cycle after acceptance, with st_addr = A + sign-extended immediate; busy stays 1 from then until the cycle st_ack is seen (including the st_req cycle), new instructions and st_ack outside busy are ignored, and the cycle after the acknowledge res_vld is 1 with res_data = st_rdata.
- R11: Class 6, or class 0 with a function code outside 0-3 and 8-12, gives res_vld = 1, res_illegal = 1, res_data = 0 and leaves carry unchanged.
- R12: Carry changes only on accepted functions 0-3 of class 0; class 7 produces no res_vld and no other change.
- R13: Every non-read instruction accepted when busy is 0 produces its result with res_vld = 1 exactly one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_vld | input | 1 | Instruction word present this cycle |
| ins_word | input | 32 | Instruction word |
| busy | output | 1 | Waiting for a state-read acknowledge; instructions ignored |
| ra_idx | output | 3 | Register index of operand A |
| rb_idx | output | 3 | Register index of operand B |
| ra_data | input | 32 | Contents of register ra_idx |
| rb_data | input | 32 | Contents of register rb_idx |
| st_req | output | 1 | One-cycle state read request |
| st_addr | output | ADDR_W | State read address |
| st_ack | input | 1 | Read data valid |
| st_rdata | input | 32 | Read data |
| res_vld | output | 1 | Result valid pulse |
| res_data | output | 32 | Result value |
| res_illegal | output | 1 | Instruction encoding was not legal |
| carry | output | 1 | Persistent carry flag |

## Verification
A corrupted carry shows at the carry port on the next result and, unlike a wrong data value, keeps propagating into every later add-with-carry and subtract-with-borrow until another plain add or subtract overwrites it, so the bench follows the flag on every cycle rather than only after arithmetic. A stuck or mis-cleared busy state shows within one cycle as a missing or extra res_vld or st_req, because the reference model predicts the exact cycle of each. Bitfield shift or mask faults appear immediately in res_data, which is why the operands carry distinct bit patterns across the field boundaries and include the size-zero and wrap-around shift cases.

// File: rtl/mcr_pkg.sv
package mcr_pkg;

   localparam int unsigned WORD_W  = 32;
   localparam int unsigned IDX_W   = 3;
   localparam int unsigned POS_W   = 5;
   localparam int unsigned FN_W    = 5;

   // Field positions the encoding depends on.
   localparam int unsigned A_LSB   = 11;
   localparam int unsigned B_LSB   = 14;
   localparam int unsigned FN_LSB  = 17;
   localparam int unsigned SZ_LSB  = 22;
   localparam int unsigned DST_LSB = 27;
   localparam int unsigned IMM_LSB = 14;
   localparam int unsigned IMM_W   = WORD_W - IMM_LSB;

   typedef enum logic [2:0] {
      CL_REG     = 3'd0,
      CL_ADDI    = 3'd1,
      CL_BFREP   = 3'd2,
      CL_BFX_IMM = 3'd3,
      CL_BFX_REG = 3'd4,
      CL_RDIMM   = 3'd5,
      CL_RSV     = 3'd6,
      CL_BRANCH  = 3'd7
   } mcr_class_e;

   localparam logic [FN_W-1:0] FN_ADD  = 5'd0;
   localparam logic [FN_W-1:0] FN_ADC  = 5'd1;
   localparam logic [FN_W-1:0] FN_SUB  = 5'd2;
   localparam logic [FN_W-1:0] FN_SBB  = 5'd3;
   localparam logic [FN_W-1:0] FN_XOR  = 5'd8;
   localparam logic [FN_W-1:0] FN_OR   = 5'd9;
   localparam logic [FN_W-1:0] FN_AND  = 5'd10;
   localparam logic [FN_W-1:0] FN_ANDN = 5'd11;
   localparam logic [FN_W-1:0] FN_NAND = 5'd12;

   typedef struct packed {
      mcr_class_e         cls;
      logic [IDX_W-1:0]   a_idx;
      logic [IDX_W-1:0]   b_idx;
      logic [FN_W-1:0]    fn;
      logic [POS_W-1:0]   src;
      logic [POS_W-1:0]   size;
      logic [POS_W-1:0]   dst;
      logic [WORD_W-1:0]  imm;
   } mcr_fields_t;

endpackage

// File: rtl/mcr_decode.sv
module mcr_decode
   import mcr_pkg::*;
(
   input  logic [WORD_W-1:0] word,
   output mcr_fields_t       fld,
   output logic              illegal,
   output logic              is_arith
);

   logic fn_ok;
   logic unused_mid;

   assign unused_mid = ^word[A_LSB-1:3];

   always_comb begin
      fld.cls   = mcr_class_e'(word[2:0]);
      fld.a_idx = word[A_LSB +: IDX_W];
      fld.b_idx = word[B_LSB +: IDX_W];
      fld.fn    = word[FN_LSB +: FN_W];
      fld.src   = word[FN_LSB +: POS_W];
      fld.size  = word[SZ_LSB +: POS_W];
      fld.dst   = word[DST_LSB +: POS_W];
      fld.imm   = {{IMM_LSB{word[WORD_W-1]}}, word[WORD_W-1:IMM_LSB]};
   end

   always_comb begin
      unique case (fld.fn)
         FN_ADD, FN_ADC, FN_SUB, FN_SBB,
         FN_XOR, FN_OR, FN_AND, FN_ANDN, FN_NAND: fn_ok = 1'b1;
         default:                                 fn_ok = 1'b0;
      endcase
   end

   assign illegal  = (fld.cls == CL_RSV) || ((fld.cls == CL_REG) && !fn_ok);
   assign is_arith = (fld.cls == CL_REG) && (fld.fn < 5'd4);

endmodule

// File: rtl/mcr_regalu.sv
module mcr_regalu
   import mcr_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  logic [FN_W-1:0]   fn,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              carry_in,
   output logic [DATA_W-1:0] result,
   output logic              carry_out
);

   logic              is_sub;
   logic              use_c;
   logic              cin;
   logic [DATA_W-1:0] b_eff;
   logic [DATA_W:0]   sum;

   // One adder serves all four arithmetic forms: subtraction adds ~B
   // with carry-in 1 (plain) or the stored carry (with borrow).
   assign is_sub = (fn == FN_SUB) || (fn == FN_SBB);
   assign use_c  = (fn == FN_ADC) || (fn == FN_SBB);
   assign cin    = use_c ? carry_in : is_sub;
   assign b_eff  = is_sub ? ~b : b;
   assign sum    = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};

   assign carry_out = sum[DATA_W];

   always_comb begin
      unique case (fn)
         FN_XOR:  result = a ^ b;
         FN_OR:   result = a | b;
         FN_AND:  result = a & b;
         FN_ANDN: result = a & ~b;
         FN_NAND: result = ~(a & b);
         default: result = sum[DATA_W-1:0];
      endcase
   end

endmodule

// File: rtl/mcr_shift.sv
module mcr_shift #(
   parameter int unsigned W      = 32,
   parameter bit          LEFT   = 1'b1,
   parameter bit          BARREL = 1'b1,
   localparam int unsigned SW    = $clog2(W)
) (
   input  logic [W-1:0]  din,
   input  logic [SW-1:0] amt,
   output logic [W-1:0]  dout
);

   generate
      if (BARREL) begin : g_stages
         logic [W-1:0] stg [0:SW];
         assign stg[0] = din;
         for (genvar k = 0; k < SW; k++) begin : g_stage
            if (LEFT) begin : g_l
               assign stg[k+1] = amt[k] ? (stg[k] << (2**k)) : stg[k];
            end else begin : g_r
               assign stg[k+1] = amt[k] ? (stg[k] >> (2**k)) : stg[k];
            end
         end
         assign dout = stg[SW];
      end else begin : g_flat
         if (LEFT) begin : g_l
            assign dout = din << amt;
         end else begin : g_r
            assign dout = din >> amt;
         end
      end
   endgenerate

endmodule

// File: rtl/mcr_bitfield.sv
module mcr_bitfield
   import mcr_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter bit          BARREL = 1'b1,
   localparam int unsigned SW    = $clog2(DATA_W)
) (
   input  mcr_class_e        cls,
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [SW-1:0]     src,
   input  logic [SW-1:0]     size,
   input  logic [SW-1:0]     dst,
   output logic [DATA_W-1:0] result
);

   logic [SW-1:0]     r_amt;
   logic [SW-1:0]     l_amt;
   logic [DATA_W-1:0] mask;
   logic [DATA_W-1:0] b_shr;
   logic [DATA_W-1:0] placed;
   logic [DATA_W-1:0] hole;
   logic [DATA_W-1:0] a_lo;

   assign a_lo  = a;
   assign r_amt = (cls == CL_BFX_IMM) ? a_lo[SW-1:0] : src;
   assign l_amt = (cls == CL_BFX_REG) ? a_lo[SW-1:0] : dst;
   assign mask  = ~({DATA_W{1'b1}} << size);

   mcr_shift #(.W(DATA_W), .LEFT(1'b0), .BARREL(BARREL)) u_rsh (
      .din(b), .amt(r_amt), .dout(b_shr));

   mcr_shift #(.W(DATA_W), .LEFT(1'b1), .BARREL(BARREL)) u_lsh (
      .din(b_shr & mask), .amt(l_amt), .dout(placed));

   mcr_shift #(.W(DATA_W), .LEFT(1'b1), .BARREL(BARREL)) u_hole (
      .din(mask), .amt(dst), .dout(hole));

   assign result = (cls == CL_BFREP) ? (placed | (a & ~hole)) : placed;

endmodule

// File: rtl/mcr_exec.sv
module mcr_exec
   import mcr_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 32,
   parameter bit          BARREL = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_vld,
   input  logic [DATA_W-1:0] ins_word,
   output logic              busy,
   output logic [2:0]        ra_idx,
   output logic [2:0]        rb_idx,
   input  logic [DATA_W-1:0] ra_data,
   input  logic [DATA_W-1:0] rb_data,
   output logic              st_req,
   output logic [ADDR_W-1:0] st_addr,
   input  logic              st_ack,
   input  logic [DATA_W-1:0] st_rdata,
   output logic              res_vld,
   output logic [DATA_W-1:0] res_data,
   output logic              res_illegal,
   output logic              carry
);

   localparam int unsigned SW = $clog2(DATA_W);

   generate
      if (DATA_W != WORD_W) begin : g_bad_data_w
         $error("mcr_exec: DATA_W must match the 32-bit instruction encoding");
      end
      if ((ADDR_W < 1) || (ADDR_W > DATA_W)) begin : g_bad_addr_w
         $error("mcr_exec: ADDR_W must lie in 1..DATA_W");
      end
   endgenerate

   mcr_fields_t       fld;
   logic              illegal;
   logic              is_arith;
   logic [DATA_W-1:0] a_val;
   logic [DATA_W-1:0] b_val;
   logic [DATA_W-1:0] alu_res;
   logic              alu_cout;
   logic [DATA_W-1:0] bf_res;
   logic [DATA_W-1:0] imm_sum;
   logic [DATA_W-1:0] ex_res;
   logic              accept;

   logic              busy_q;
   logic              st_req_q;
   logic [ADDR_W-1:0] st_addr_q;
   logic              res_vld_q;
   logic [DATA_W-1:0] res_data_q;
   logic              res_ill_q;
   logic              carry_q;

   mcr_decode u_dec (
      .word     (ins_word),
      .fld      (fld),
      .illegal  (illegal),
      .is_arith (is_arith)
   );

   assign ra_idx = fld.a_idx;
   assign rb_idx = fld.b_idx;
   assign a_val  = (fld.a_idx == '0) ? '0 : ra_data;
   assign b_val  = (fld.b_idx == '0) ? '0 : rb_data;

   mcr_regalu #(.DATA_W(DATA_W)) u_alu (
      .fn        (fld.fn),
      .a         (a_val),
      .b         (b_val),
      .carry_in  (carry_q),
      .result    (alu_res),
      .carry_out (alu_cout)
   );

   mcr_bitfield #(.DATA_W(DATA_W), .BARREL(BARREL)) u_bf (
      .cls    (fld.cls),
      .a      (a_val),
      .b      (b_val),
      .src    (fld.src[SW-1:0]),
      .size   (fld.size[SW-1:0]),
      .dst    (fld.dst[SW-1:0]),
      .result (bf_res)
   );

   // Shared by add-immediate and the read address.
   assign imm_sum = a_val + fld.imm;

   always_comb begin
      unique case (fld.cls)
         CL_REG:                           ex_res = alu_res;
         CL_ADDI:                          ex_res = imm_sum;
         CL_BFREP, CL_BFX_IMM, CL_BFX_REG: ex_res = bf_res;
         default:                          ex_res = '0;
      endcase
   end

   assign accept = ins_vld && !busy_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         st_req_q   <= 1'b0;
         st_addr_q  <= '0;
         res_vld_q  <= 1'b0;
         res_data_q <= '0;
         res_ill_q  <= 1'b0;
         carry_q    <= 1'b0;
      end else begin
         res_vld_q <= 1'b0;
         st_req_q  <= 1'b0;
         if (busy_q) begin
            if (st_ack) begin
               busy_q     <= 1'b0;
               res_vld_q  <= 1'b1;
               res_data_q <= st_rdata;
               res_ill_q  <= 1'b0;
            end
         end else if (accept) begin
            if (fld.cls == CL_RDIMM) begin
               busy_q    <= 1'b1;
               st_req_q  <= 1'b1;
               st_addr_q <= imm_sum[ADDR_W-1:0];
            end else if (fld.cls != CL_BRANCH) begin
               res_vld_q  <= 1'b1;
               res_data_q <= illegal ? '0 : ex_res;
               res_ill_q  <= illegal;
               if (is_arith) begin
                  carry_q <= alu_cout;
               end
            end
         end
      end
   end

   assign busy        = busy_q;
   assign st_req      = st_req_q;
   assign st_addr     = st_addr_q;
   assign res_vld     = res_vld_q;
   assign res_data    = res_data_q;
   assign res_illegal = res_ill_q;
   assign carry       = carry_q;

endmodule

// File: rtl/mcr_exec_chk.sv
module mcr_exec_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ins_vld,
   input logic [DATA_W-1:0] ins_word,
   input logic              busy,
   input logic              st_req,
   input logic              st_ack,
   input logic              res_vld,
   input logic              res_illegal,
   input logic [DATA_W-1:0] res_data,
   input logic              carry
);

   logic       take;
   logic [2:0] cls;
   logic       arith;

   assign take  = ins_vld && !busy;
   assign cls   = ins_word[2:0];
   assign arith = (cls == 3'd0) && (ins_word[21:17] < 5'd4);

   p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!res_vld && !busy && !st_req && !carry));

   p_illegal_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (res_vld && res_illegal) |-> (res_data == '0));

   p_carry_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !arith) |=> $stable(carry));

   p_idle_carry_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(carry));

   p_branch_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (take && cls == 3'd7) |=> (!res_vld && !busy && !st_req));

   p_read_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (take && cls == 3'd5) |=> (st_req && busy && !res_vld));

   p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      st_req |=> !st_req);

   p_wait_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !st_ack) |=> (busy && !res_vld));

   p_ack_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && st_ack) |=> (!busy && res_vld && !res_illegal));

   p_result_next_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (take && cls != 3'd5 && cls != 3'd7) |=> res_vld);

endmodule

bind mcr_exec mcr_exec_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ins_vld     (ins_vld),
   .ins_word    (ins_word),
   .busy        (busy),
   .st_req      (st_req),
   .st_ack      (st_ack),
   .res_vld     (res_vld),
   .res_illegal (res_illegal),
   .res_data    (res_data),
   .carry       (carry)
);

// File: tb/mcr_exec_tb.sv
module mcr_exec_tb;

   localparam int CLK_PERIOD = 10;
   localparam int WDOG_CYC   = 20000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ins_vld = 1'b0;
   logic [31:0] ins_word = '0;
   logic        busy;
   logic [2:0]  ra_idx, rb_idx;
   logic [31:0] ra_data = '0, rb_data = '0;
   logic        st_req;
   logic [31:0] st_addr;
   logic        st_ack = 1'b0;
   logic [31:0] st_rdata = '0;
   logic        res_vld;
   logic [31:0] res_data;
   logic        res_illegal;
   logic        carry;

   always #(CLK_PERIOD/2) clk = ~clk;

   mcr_exec u_dut (
      .clk(clk), .rst_n(rst_n), .ins_vld(ins_vld), .ins_word(ins_word),
      .busy(busy), .ra_idx(ra_idx), .rb_idx(rb_idx),
      .ra_data(ra_data), .rb_data(rb_data),
      .st_req(st_req), .st_addr(st_addr), .st_ack(st_ack), .st_rdata(st_rdata),
      .res_vld(res_vld), .res_data(res_data), .res_illegal(res_illegal),
      .carry(carry));

   int n_run = 0;
   int n_fail = 0;

   logic [31:0] regs [8];

   // reference model state
   logic        m_busy = 0, m_carry = 0, m_vld = 0, m_ill = 0, m_req = 0;
   logic [31:0] m_data = 0, m_addr = 0, p_addr = 0;
   string       m_tag = "R1", m_ctag = "R1";

   function automatic logic [31:0] memf(input logic [31:0] ad);
      return {ad[15:0], ~ad[15:0]} ^ 32'h0F0F_3C3C;
   endfunction

   function automatic logic [31:0] enc_reg(input logic [4:0] fn, input logic [2:0] a, b);
      return {10'd0, fn, b, a, 8'h50, 3'd0};
   endfunction
   function automatic logic [31:0] enc_imm(input logic [2:0] cl, input logic [2:0] a, input logic [17:0] imm);
      return {imm, a, 8'h30, cl};
   endfunction
   function automatic logic [31:0] enc_bf(input logic [2:0] cl, input logic [2:0] a, b,
                                          input logic [4:0] src, size, dst);
      return {dst, size, src, b, a, 8'h00, cl};
   endfunction

   task automatic chk(input string tag, input string what, input logic [31:0] act, exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare();
      chk(m_tag, "res_vld", {31'd0, res_vld}, {31'd0, m_vld});
      if (m_vld) begin
         chk(m_tag, "res_data", res_data, m_data);
         chk(m_tag, "res_illegal", {31'd0, res_illegal}, {31'd0, m_ill});
      end
      chk(m_ctag, "carry", {31'd0, carry}, {31'd0, m_carry});
      chk("R10", "busy", {31'd0, busy}, {31'd0, m_busy});
      chk("R10", "st_req", {31'd0, st_req}, {31'd0, m_req});
      if (m_req) chk("R10", "st_addr", st_addr, m_addr);
   endtask

   task automatic model_step(input logic v, input logic [31:0] w, input logic ack);
      logic [31:0] a, b, mask, sx, fld;
      longint      s;
      int          sz;
      m_vld = 0;
      m_req = 0;
      if (m_busy) begin
         if (ack) begin
            m_vld = 1; m_data = memf(p_addr); m_ill = 0; m_busy = 0; m_tag = "R10";
         end
      end else if (v) begin
         a  = (w[13:11] == 0) ? 32'd0 : regs[w[13:11]];
         b  = (w[16:14] == 0) ? 32'd0 : regs[w[16:14]];
         sx = {{14{w[31]}}, w[31:14]};
         sz = int'(w[26:22]);
         mask = 32'((64'd1 << sz) - 64'd1);
         m_vld = 1; m_ill = 0; m_ctag = "R12";
         case (w[2:0])
            3'd0: begin
               m_tag = "R5";
               case (w[21:17])
                  5'd0: begin s = longint'(a) + longint'(b); m_data = 32'(s);
                     m_carry = (s > 64'hFFFF_FFFF); m_tag = "R3"; m_ctag = "R3"; end
                  5'd1: begin s = longint'(a) + longint'(b) + longint'(m_carry); m_data = 32'(s);
                     m_carry = (s > 64'hFFFF_FFFF); m_tag = "R3"; m_ctag = "R3"; end
                  5'd2: begin m_data = a - b; m_carry = (a >= b); m_tag = "R4"; m_ctag = "R4"; end
                  5'd3: begin
                     s = longint'(a) - longint'(b) - longint'(1 - int'(m_carry));
                     m_data = 32'(s); m_carry = (s >= 0); m_tag = "R4"; m_ctag = "R4"; end
                  5'd8:  m_data = a ^ b;
                  5'd9:  m_data = a | b;
                  5'd10: m_data = a & b;
                  5'd11: m_data = a & ~b;
                  5'd12: m_data = ~(a & b);
                  default: begin m_data = 0; m_ill = 1; m_tag = "R11"; m_ctag = "R11"; end
               endcase
            end
            3'd1: begin m_data = a + sx; m_tag = "R6"; end
            3'd2: begin
               fld = ((b >> w[21:17]) & mask) << w[31:27];
               m_data = (a & ~(mask << w[31:27])) | fld; m_tag = "R7";
            end
            3'd3: begin m_data = ((b >> a[4:0]) & mask) << w[31:27]; m_tag = "R8"; end
            3'd4: begin m_data = ((b >> w[21:17]) & mask) << a[4:0]; m_tag = "R9"; end
            3'd5: begin
               m_vld = 0; m_busy = 1; m_req = 1; m_addr = a + sx; p_addr = a + sx; m_tag = "R10";
            end
            3'd6: begin m_data = 0; m_ill = 1; m_tag = "R11"; m_ctag = "R11"; end
            default: begin m_vld = 0; m_tag = "R12"; end
         endcase
      end
   endtask

   task automatic cyc(input logic v, input logic [31:0] w, input logic ack);
      @(negedge clk);
      compare();
      ins_vld  = v;
      ins_word = w;
      ra_data  = regs[w[13:11]];
      rb_data  = regs[w[16:14]];
      st_ack   = ack;
      st_rdata = memf(p_addr);
      #1;
      chk("R2", "ra_idx", {29'd0, ra_idx}, {29'd0, w[13:11]});
      chk("R2", "rb_idx", {29'd0, rb_idx}, {29'd0, w[16:14]});
      @(posedge clk);
      model_step(v, w, ack);
   endtask

   initial begin
      repeat (WDOG_CYC) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      regs[0] = 32'hDEAD_BEEF;   // R2: must read as zero
      regs[1] = 32'hFFFF_FFFF;
      regs[2] = 32'h0000_0001;
      regs[3] = 32'h1234_5678;
      regs[4] = 32'h8000_0000;
      regs[5] = 32'h0000_0005;
      regs[6] = 32'hA5A5_F00F;
      regs[7] = 32'h0000_0024;   // shift of 36 wraps to 4
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state checked by the first compare
      cyc(0, 0, 0);
      // R3 add / add-with-carry
      cyc(1, enc_reg(5'd0, 3'd1, 3'd2), 0);
      cyc(1, enc_reg(5'd1, 3'd3, 3'd0), 0);
      cyc(1, enc_reg(5'd1, 3'd1, 3'd1), 0);
      cyc(1, enc_reg(5'd1, 3'd0, 3'd0), 0);
      // R4 subtract / with borrow
      cyc(1, enc_reg(5'd2, 3'd2, 3'd1), 0);
      cyc(1, enc_reg(5'd3, 3'd0, 3'd0), 0);
      cyc(1, enc_reg(5'd2, 3'd3, 3'd2), 0);
      cyc(1, enc_reg(5'd3, 3'd3, 3'd3), 0);
      cyc(1, enc_reg(5'd3, 3'd4, 3'd2), 0);
      // R5 logic, carry must hold (R12)
      for (int f = 8; f <= 12; f++) cyc(1, enc_reg(5'(f), 3'd6, 3'd3), 0);
      cyc(1, enc_reg(5'd12, 3'd0, 3'd7), 0);
      // R11 illegal codes
      cyc(1, enc_reg(5'd5, 3'd1, 3'd2), 0);
      cyc(1, enc_reg(5'd13, 3'd1, 3'd2), 0);
      cyc(1, enc_reg(5'd31, 3'd1, 3'd1), 0);
      cyc(1, enc_imm(3'd6, 3'd3, 18'h0_1234), 0);
      // R6 add-immediate
      cyc(1, enc_imm(3'd1, 3'd3, 18'h3_FFFF), 0);
      cyc(1, enc_imm(3'd1, 3'd1, 18'h1_FFFF), 0);
      cyc(1, enc_imm(3'd1, 3'd0, 18'h2_0000), 0);
      // R7 field insert
      cyc(1, enc_bf(3'd2, 3'd6, 3'd3, 5'd4, 5'd8, 5'd12), 0);
      cyc(1, enc_bf(3'd2, 3'd6, 3'd3, 5'd4, 5'd0, 5'd12), 0);
      cyc(1, enc_bf(3'd2, 3'd1, 3'd0, 5'd0, 5'd31, 5'd1), 0);
      // R8 extract, right shift from A
      cyc(1, enc_bf(3'd3, 3'd5, 3'd3, 5'd9, 5'd12, 5'd3), 0);
      cyc(1, enc_bf(3'd3, 3'd7, 3'd6, 5'd0, 5'd20, 5'd0), 0);
      // R9 extract, left shift from A
      cyc(1, enc_bf(3'd4, 3'd5, 3'd6, 5'd8, 5'd16, 5'd0), 0);
      cyc(1, enc_bf(3'd4, 3'd4, 3'd6, 5'd28, 5'd7, 5'd0), 0);
      cyc(1, enc_bf(3'd4, 3'd7, 3'd1, 5'd0, 5'd3, 5'd0), 0);
      // R10 read: delayed acknowledge, instructions ignored while busy
      cyc(1, enc_imm(3'd5, 3'd3, 18'h3_FFF8), 0);
      cyc(1, enc_reg(5'd0, 3'd1, 3'd2), 0);
      cyc(1, enc_imm(3'd5, 3'd2, 18'h0_0010), 0);
      cyc(0, 0, 1);
      cyc(0, 0, 0);
      // R10 acknowledge in the request cycle, stray ack when idle
      cyc(1, enc_imm(3'd5, 3'd0, 18'h0_0400), 0);
      cyc(0, 0, 1);
      cyc(0, 0, 1);
      // R12 branch words produce nothing
      cyc(1, 32'hFFFF_FFFF, 0);
      cyc(1, enc_reg(5'd0, 3'd1, 3'd1) | 32'h7, 0);
      // R13 back-to-back results
      cyc(1, enc_reg(5'd0, 3'd1, 3'd1), 0);
      cyc(1, enc_imm(3'd1, 3'd2, 18'h0_0002), 0);
      cyc(0, 0, 0);
      cyc(0, 0, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule